// File: doc/BRIEF.md
# Display Panel Power-Up Sequencer

This block brings a TFT display controller from power-on to a running display. A one-cycle start pulse launches a fixed routine. The block first pulls the panel's hardware reset line low for a set time and then releases it. It then sends a short series of command and parameter bytes through a byte-wide write port. That port is normally a parallel bus write engine that takes one byte per valid/ready handshake, together with a flag that separates command bytes from data bytes.

The bytes go out in this order:
- soft reset
- display off
- pixel-format select, with the 16-bit parameter
- sleep out
- display on

The block pauses after the soft reset and after sleep out. When the display-on byte has been accepted, a done flag rises and stays high until the routine is started again. Every delay is a parameter counted in clock cycles, and each delay has its own parameter.

Top module: `panel_powerup_seq`

## Requirements
- R1: After reset, `panel_rst_n_o` is 1, `wr_valid_o` is 0 and `done_o` is 0.
- R2: A start pulse sampled while idle or done pulls `panel_rst_n_o` low from the next cycle, for exactly HOLD_CYC cycles. The line then returns high and stays high for the rest of the routine.
- R3: The bytes are accepted in the order 0x01, 0x28, 0x3A, 0x55, 0x11, 0x29. `wr_is_data_o` is 1 (data) only for 0x55 and 0 (command) for the other five.
- R4: While `wr_valid_o` is 1 and `wr_ready_i` is 0, the byte and the flag hold steady and `wr_valid_o` stays high. A byte counts as sent only at a clock edge where both `wr_valid_o` and `wr_ready_i` are 1.
- R5: After 0x01 is accepted, `wr_valid_o` stays low for exactly SWRST_WAIT_CYC cycles before 0x28 is offered.
- R6: After 0x11 is accepted, `wr_valid_o` stays low for exactly WAKE_WAIT_CYC cycles before 0x29 is offered.
- R7: A start pulse that arrives while the routine is running (reset hold, sending or waiting) is ignored. The reset line is not pulsed again and no byte is repeated or skipped.
- R8: `done_o` rises in the cycle after 0x29 is accepted and holds with `wr_valid_o` low until a new start pulse. The cycle after that pulse, `done_o` is 0 and the routine runs again.
- R9: When no pause is due, the next byte is offered in the cycle right after the previous one is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to run the power-up routine |
| wr_ready_i | input | 1 | Write port can take a byte this cycle |
| panel_rst_n_o | output | 1 | Hardware reset line to the panel, active low |
| wr_valid_o | output | 1 | A byte is offered on the write port |
| wr_is_data_o | output | 1 | 1 = data byte, 0 = command byte |
| wr_byte_o | output | 8 | Byte offered on the write port |
| done_o | output | 1 | Display is on |

## Verification
Some properties are checked by assertions on every cycle:
- an offered byte stays stable under back-pressure;
- no byte is offered while the reset line is low or once done;
- only the pixel-format parameter carries the data flag;
- done holds until a start;
- a start during sending does not touch the reset line.

Other behaviour needs whole-run observation, so only the bench's scenarios show it: the exact reset-hold length, the full byte order, and the exact lengths of the two pauses. The same scenarios also cover ignored starts that land in the reset hold, in a pause or in a send, and a restart from the done state.

// File: rtl/panel_powerup_pkg.sv
package panel_powerup_pkg;

    localparam int unsigned STEP_COUNT = 6;
    localparam int unsigned STEP_IDX_W = $clog2(STEP_COUNT);

    localparam logic [7:0] CODE_SOFT_RESET  = 8'h01;
    localparam logic [7:0] CODE_DISP_OFF    = 8'h28;
    localparam logic [7:0] CODE_PIX_FORMAT  = 8'h3A;
    localparam logic [7:0] ARG_PIX_16BIT    = 8'h55;
    localparam logic [7:0] CODE_SLEEP_OUT   = 8'h11;
    localparam logic [7:0] CODE_DISP_ON     = 8'h29;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_SEND,
        ST_PAUSE,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        PAUSE_NONE,
        PAUSE_AFTER_SWRST,
        PAUSE_AFTER_WAKE
    } pause_e;

    typedef struct packed {
        logic       is_data;
        logic [7:0] code;
        pause_e     pause;
        logic       last;
    } seq_step_t;

    typedef struct packed {
        seq_state_e            state;
        logic [STEP_IDX_W-1:0] idx;
    } seq_ctl_t;

endpackage

// File: rtl/panel_powerup_steps.sv
module panel_powerup_steps
    import panel_powerup_pkg::*;
(
    input  logic [STEP_IDX_W-1:0] idx_i,
    output seq_step_t             step_o
);

    always_comb begin
        step_o = '{is_data: 1'b0, code: CODE_DISP_ON, pause: PAUSE_NONE, last: 1'b1};
        case (idx_i)
            STEP_IDX_W'(0): step_o = '{is_data: 1'b0, code: CODE_SOFT_RESET, pause: PAUSE_AFTER_SWRST, last: 1'b0};
            STEP_IDX_W'(1): step_o = '{is_data: 1'b0, code: CODE_DISP_OFF,   pause: PAUSE_NONE,        last: 1'b0};
            STEP_IDX_W'(2): step_o = '{is_data: 1'b0, code: CODE_PIX_FORMAT, pause: PAUSE_NONE,        last: 1'b0};
            STEP_IDX_W'(3): step_o = '{is_data: 1'b1, code: ARG_PIX_16BIT,   pause: PAUSE_NONE,        last: 1'b0};
            STEP_IDX_W'(4): step_o = '{is_data: 1'b0, code: CODE_SLEEP_OUT,  pause: PAUSE_AFTER_WAKE,  last: 1'b0};
            default:        step_o = '{is_data: 1'b0, code: CODE_DISP_ON,    pause: PAUSE_NONE,        last: 1'b1};
        endcase
    end

endmodule

// File: rtl/panel_powerup_timer.sv
module panel_powerup_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/panel_powerup_seq.sv
module panel_powerup_seq
    import panel_powerup_pkg::*;
#(
    parameter int unsigned HOLD_CYC       = 1000,
    parameter int unsigned SWRST_WAIT_CYC = 5000,
    parameter int unsigned WAKE_WAIT_CYC  = 12000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       wr_ready_i,
    output logic       panel_rst_n_o,
    output logic       wr_valid_o,
    output logic       wr_is_data_o,
    output logic [7:0] wr_byte_o,
    output logic       done_o
);

    localparam int unsigned MAX_A   = (HOLD_CYC > SWRST_WAIT_CYC) ? HOLD_CYC : SWRST_WAIT_CYC;
    localparam int unsigned MAX_DLY = (MAX_A > WAKE_WAIT_CYC) ? MAX_A : WAKE_WAIT_CYC;
    localparam int unsigned CNT_W   = $clog2(MAX_DLY + 1);

    localparam logic [CNT_W-1:0] HOLD_LOAD  = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] SWRST_LOAD = CNT_W'(SWRST_WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] WAKE_LOAD  = CNT_W'(WAKE_WAIT_CYC - 1);

    seq_ctl_t         ctl_d, ctl_q;
    seq_step_t        step;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;

    panel_powerup_steps u_steps (
        .idx_i  (ctl_q.idx),
        .step_o (step)
    );

    panel_powerup_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (ctl_q.state)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    ctl_d.state = ST_HOLD;
                    ctl_d.idx   = '0;
                    tmr_load    = 1'b1;
                    tmr_val     = HOLD_LOAD;
                end
            end
            ST_HOLD: begin
                if (tmr_expired) begin
                    ctl_d.state = ST_SEND;
                end
            end
            ST_SEND: begin
                if (wr_ready_i) begin
                    if (step.pause == PAUSE_AFTER_SWRST) begin
                        ctl_d.state = ST_PAUSE;
                        tmr_load    = 1'b1;
                        tmr_val     = SWRST_LOAD;
                    end else if (step.pause == PAUSE_AFTER_WAKE) begin
                        ctl_d.state = ST_PAUSE;
                        tmr_load    = 1'b1;
                        tmr_val     = WAKE_LOAD;
                    end else if (step.last) begin
                        ctl_d.state = ST_DONE;
                    end else begin
                        ctl_d.idx = ctl_q.idx + STEP_IDX_W'(1);
                    end
                end
            end
            ST_PAUSE: begin
                if (tmr_expired) begin
                    ctl_d.state = ST_SEND;
                    ctl_d.idx   = ctl_q.idx + STEP_IDX_W'(1);
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
                ctl_d.idx   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, idx: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign panel_rst_n_o = (ctl_q.state != ST_HOLD);
    assign wr_valid_o    = (ctl_q.state == ST_SEND);
    assign wr_is_data_o  = step.is_data;
    assign wr_byte_o     = step.code;
    assign done_o        = (ctl_q.state == ST_DONE);

endmodule

// File: rtl/panel_powerup_seq_chk.sv
module panel_powerup_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       wr_ready_i,
    input logic       panel_rst_n_o,
    input logic       wr_valid_o,
    input logic       wr_is_data_o,
    input logic [7:0] wr_byte_o,
    input logic       done_o
);

    AST_STALL_HOLDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_byte_o) && $stable(wr_is_data_o))); // R4

    AST_NO_SEND_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !panel_rst_n_o |-> !wr_valid_o); // R2

    AST_DATA_FLAG_ONLY_ARG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && wr_is_data_o) |-> (wr_byte_o == 8'h55)); // R3

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!wr_valid_o && panel_rst_n_o)); // R8

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o); // R8

    AST_START_IGNORED_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && start_i) |=> panel_rst_n_o); // R7

endmodule

bind panel_powerup_seq panel_powerup_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .wr_ready_i    (wr_ready_i),
    .panel_rst_n_o (panel_rst_n_o),
    .wr_valid_o    (wr_valid_o),
    .wr_is_data_o  (wr_is_data_o),
    .wr_byte_o     (wr_byte_o),
    .done_o        (done_o)
);

// File: tb/sim_panel_powerup_seq.sv
`timescale 1ns/1ps
module sim_panel_powerup_seq;

    localparam int HOLD  = 5;
    localparam int SWW   = 7;
    localparam int WAKEW = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       wr_ready_i = 1'b0;
    logic       panel_rst_n_o, wr_valid_o, wr_is_data_o, done_o;
    logic [7:0] wr_byte_o;

    int tests = 0;
    int fails = 0;

    int   n_acc, rst_low, unstable, done_lag;
    int   acc_byte [8];
    int   acc_flag [8];
    int   acc_gap  [8];

    always #5 clk = ~clk;

    panel_powerup_seq #(
        .HOLD_CYC       (HOLD),
        .SWRST_WAIT_CYC (SWW),
        .WAKE_WAIT_CYC  (WAKEW)
    ) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .wr_ready_i    (wr_ready_i),
        .panel_rst_n_o (panel_rst_n_o),
        .wr_valid_o    (wr_valid_o),
        .wr_is_data_o  (wr_is_data_o),
        .wr_byte_o     (wr_byte_o),
        .done_o        (done_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // mode 0: ready always; mode 1: ready one cycle in three. extra_start: cycle of a stray start, -1 none
    task automatic observe(input int mode, input int extra_start);
        int  idle = 0;
        int  last_acc = 0;
        bit  pend = 0;
        int  pb = 0;
        int  pf = 0;
        bit  fin = 0;
        n_acc = 0; rst_low = 0; unstable = 0; done_lag = -1;
        for (int i = 0; i < 8; i++) begin
            acc_byte[i] = -1; acc_flag[i] = -1; acc_gap[i] = -1;
        end
        for (int cyc = 0; cyc < 3000 && !fin; cyc++) begin
            @(negedge clk);
            start_i    = (cyc == 0) || (cyc == extra_start);
            wr_ready_i = (mode == 0) ? 1'b1 : ((cyc % 3) == 2);
            if (!panel_rst_n_o) begin
                rst_low++;
                idle = 0;
            end
            if (cyc > 0 && done_o) begin
                done_lag = cyc - last_acc;
                fin = 1;
            end else if (wr_valid_o) begin
                if (pend && (int'(wr_byte_o) != pb || int'(wr_is_data_o) != pf)) unstable++;
                if (wr_ready_i) begin
                    if (n_acc < 8) begin
                        acc_byte[n_acc] = int'(wr_byte_o);
                        acc_flag[n_acc] = int'(wr_is_data_o);
                        acc_gap[n_acc]  = idle;
                    end
                    n_acc++;
                    idle = 0;
                    pend = 0;
                    last_acc = cyc;
                end else begin
                    pend = 1;
                    pb = int'(wr_byte_o);
                    pf = int'(wr_is_data_o);
                end
            end else if (panel_rst_n_o && cyc > 0) begin
                if (pend) unstable++;
                idle++;
            end
        end
        start_i = 1'b0;
        if (!fin) begin
            tests++;
            fails++;
            $display("FAIL R8 run never reached done: actual 0 expected 1");
        end
    endtask

    task automatic check_order(input string tag);
        int exp_b [6] = '{8'h01, 8'h28, 8'h3A, 8'h55, 8'h11, 8'h29};
        check({"R3 ", tag}, "byte count", n_acc, 6);
        for (int i = 0; i < 6; i++) begin
            check({"R3 ", tag}, $sformatf("byte %0d", i), acc_byte[i], exp_b[i]);
            check({"R3 ", tag}, $sformatf("flag %0d", i), acc_flag[i], (i == 3) ? 1 : 0);
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        check("R1", "panel reset line", int'(panel_rst_n_o), 1);
        check("R1", "valid", int'(wr_valid_o), 0);
        check("R1", "done", int'(done_o), 0);
    endtask

    task automatic t_full_ready();
        observe(0, -1);
        check("R2", "reset low cycles", rst_low, HOLD);
        check_order("ready");
        check("R5", "gap after soft reset", acc_gap[1], SWW);
        check("R6", "gap after sleep out", acc_gap[5], WAKEW);
        check("R9", "gap 0x28->0x3A", acc_gap[2], 0);
        check("R9", "gap 0x3A->0x55", acc_gap[3], 0);
        check("R9", "gap 0x55->0x11", acc_gap[4], 0);
        check("R8", "done lag", done_lag, 1);
    endtask

    task automatic t_done_hold_restart();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            wr_ready_i = 1'b1;
            check("R8", "done held", int'(done_o), 1);
            check("R8", "no byte while done", int'(wr_valid_o), 0);
        end
        observe(0, -1);
        check("R2", "restart reset low cycles", rst_low, HOLD);
        check_order("restart");
        check("R8", "done after restart", done_lag, 1);
    endtask

    task automatic t_stall();
        observe(1, -1);
        check("R4", "unstable offers", unstable, 0);
        check_order("stall");
        check("R5", "stall gap after soft reset", acc_gap[1], SWW);
        check("R6", "stall gap after sleep out", acc_gap[5], WAKEW);
    endtask

    task automatic t_start_ignored(input int at);
        observe(0, at);
        check("R7", $sformatf("reset low with stray start at %0d", at), rst_low, HOLD);
        check_order("stray start");
        check("R7", "pause unchanged", acc_gap[1], SWW);
    endtask

    task automatic t_start_in_done_drops();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R8", "done after new start", int'(done_o), 0);
        check("R2", "reset line after new start", int'(panel_rst_n_o), 0);
        for (int i = 0; i < 200 && !done_o; i++) begin
            @(negedge clk);
            wr_ready_i = 1'b1;
        end
    endtask

    initial begin
        #1_000_000;
        tests++;
        fails++;
        $display("FAIL watchdog expired: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_full_ready();
        t_done_hold_restart();
        t_stall();
        t_start_ignored(3);
        t_start_ignored(6);
        t_start_ignored(12);
        t_start_ignored(17);
        t_start_in_done_drops();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule